// File: doc/BRIEF.md
# Triggered DAC Update Controller

This block holds the digital side of a 10-bit current-output DAC. Software writes a control register and two data bytes through a simple register-write port. The data bytes wait in holding registers. The word reaches the output latch only when a chosen hardware event occurs. Because of this, the time at which the analog output changes does not depend on software or interrupt latency.

A 3-bit update-mode field selects the event. It can be an overflow pulse from one of four timers, or a rising edge, a falling edge or either edge of an asynchronous external strobe pin. The strobe passes through a synchronizer before edge detection. A further mode commits the word at once when the high byte is written. The data word is left-justified across the two bytes. The commit copies both bytes in the same cycle, so the output never shows a word that is only half updated. A 2-bit full-scale range select also goes to the analog stage. It takes effect as soon as the control register is written.

Top module: `dac_update_ctrl`

## Requirements
- R1: After reset, `dac_code` is 0x000, `fs_range` is 2'b10 (the 2 mA range) and the control register reads 0x02 (update mode 000).
- R2: Register addresses: 0 is control, 1 is data high, 2 is data low. `rd_data` returns the addressed register combinationally. Address 3 reads zero.
- R3: The control register keeps only the update mode in bits [6:4] and the range in bits [1:0]; its other bits read zero. The data-low register keeps only bits 7:6; its bits 5:0 read zero.
- R4: In modes 000 to 110, writes to either data register leave `dac_code` unchanged until the selected event occurs.
- R5: Modes 000, 001, 010 and 011 commit on a pulse of `tmr_ovf[0]`, `[1]`, `[2]` and `[3]`, respectively. The commit takes effect at the clock edge that samples the pulse. Pulses on the other timer inputs have no effect.
- R6: Mode 100 commits on a rising edge of `strobe_in`. `dac_code` changes at the third rising clock edge after the new strobe level is first driven, and not earlier.
- R7: Mode 101 commits on a falling edge of `strobe_in`, with the same latency as R6. A rising edge has no effect.
- R8: Mode 110 commits on both edges of `strobe_in`, with the same latency as R6.
- R9: Mode 111 commits at the same clock edge as a write to the data-high register. The commit uses the written byte and the held low bits. Timer pulses and strobe edges have no effect in this mode.
- R10: A commit sets `dac_code` to {data_high[7:0], data_low[7:6]}, with both bytes taken as held at that edge.
- R11: `fs_range` follows control bits [1:0] from the clock edge of the control write. The encoding is 1x = 2 mA, 01 = 1 mA, 00 = 0.5 mA.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write enable |
| wr_addr | input | 2 | Write address |
| wr_data | input | 8 | Write data |
| rd_addr | input | 2 | Read address |
| rd_data | output | 8 | Read data (combinational) |
| tmr_ovf | input | 4 | Timer overflow pulses, one per timer |
| strobe_in | input | 1 | Asynchronous external convert strobe |
| dac_code | output | 10 | Latched DAC code |
| fs_range | output | 2 | Full-scale range select |

## Verification
Register writes, timer commits, high-byte commits and range changes all show at the ports at the clock edge that samples them. The bench drives stimulus on the falling edge and samples on the next falling edge, half a cycle after the result is due. A strobe edge needs three rising clock edges: two synchronizer flops and one edge-detect flop. The bench therefore checks that `dac_code` is still unchanged after two edges and has the new value after the third. Readback is combinational and is sampled in the same low phase in which the address is set.

// File: rtl/dacu_pkg.sv
package dacu_pkg;
    localparam int BYTE_W    = 8;
    localparam int CODE_W    = 10;
    localparam int LSB_BITS  = CODE_W - BYTE_W;
    localparam int NUM_TMR   = 4;
    localparam int ADDR_W    = 2;
    localparam int MODE_W    = 3;
    localparam int RANGE_W   = 2;

    typedef enum logic [MODE_W-1:0] {
        UPD_TMR0  = 3'b000,
        UPD_TMR1  = 3'b001,
        UPD_TMR2  = 3'b010,
        UPD_TMR3  = 3'b011,
        UPD_RISE  = 3'b100,
        UPD_FALL  = 3'b101,
        UPD_BOTH  = 3'b110,
        UPD_WRITE = 3'b111
    } upd_mode_e;

    typedef enum logic [ADDR_W-1:0] {
        REG_CTRL = 2'd0,
        REG_HI   = 2'd1,
        REG_LO   = 2'd2,
        REG_NONE = 2'd3
    } reg_addr_e;

    typedef struct packed {
        upd_mode_e          mode;
        logic [RANGE_W-1:0] range;
    } ctrl_t;

    localparam logic [RANGE_W-1:0] RANGE_RST = 2'b10;
    localparam ctrl_t CTRL_RST = '{mode: UPD_TMR0, range: RANGE_RST};

    function automatic logic [BYTE_W-1:0] keep_lsbs(input logic [BYTE_W-1:0] b);
        logic [BYTE_W-1:0] r;
        r = '0;
        r[BYTE_W-1 -: LSB_BITS] = b[BYTE_W-1 -: LSB_BITS];
        return r;
    endfunction

    function automatic logic [CODE_W-1:0] join_word(input logic [BYTE_W-1:0] hi,
                                                    input logic [BYTE_W-1:0] lo);
        return {hi, lo[BYTE_W-1 -: LSB_BITS]};
    endfunction

    function automatic logic [BYTE_W-1:0] ctrl_to_byte(input ctrl_t c);
        logic [BYTE_W-1:0] r;
        r = '0;
        r[6:4] = c.mode;
        r[1:0] = c.range;
        return r;
    endfunction
endpackage

// File: rtl/dacu_regs.sv
module dacu_regs
    import dacu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [BYTE_W-1:0] wr_data,
    input  logic [ADDR_W-1:0] rd_addr,
    output logic [BYTE_W-1:0] rd_data,
    output ctrl_t             ctrl_q,
    output logic [BYTE_W-1:0] hold_hi,
    output logic [BYTE_W-1:0] hold_lo,
    output logic              hi_wr
);
    logic ctrl_wr, lo_wr;

    always_comb begin
        ctrl_wr = wr_en && (wr_addr == REG_CTRL);
        hi_wr   = wr_en && (wr_addr == REG_HI);
        lo_wr   = wr_en && (wr_addr == REG_LO);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= CTRL_RST;
            hold_hi <= '0;
            hold_lo <= '0;
        end else begin
            if (ctrl_wr) begin
                ctrl_q.mode  <= upd_mode_e'(wr_data[6:4]);
                ctrl_q.range <= wr_data[1:0];
            end
            if (hi_wr) hold_hi <= wr_data;
            if (lo_wr) hold_lo <= keep_lsbs(wr_data);
        end
    end

    always_comb begin
        unique case (reg_addr_e'(rd_addr))
            REG_CTRL: rd_data = ctrl_to_byte(ctrl_q);
            REG_HI:   rd_data = hold_hi;
            REG_LO:   rd_data = hold_lo;
            default:  rd_data = '0;
        endcase
    end
endmodule

// File: rtl/dacu_trigger.sv
module dacu_trigger
    import dacu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  upd_mode_e          mode,
    input  logic [NUM_TMR-1:0] tmr_ovf,
    input  logic               strobe_in,
    input  logic               hi_wr,
    output logic               commit
);
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   strobe_prev;
    logic                   strobe_s;
    logic                   rise_ev, fall_ev;
    logic                   tmr_hit;

    generate
        if (SYNC_STAGES == 1) begin : g_one
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= strobe_in;
            end
        end else begin : g_chain
            always_ff @(posedge clk) begin
                if (rst) sync_q <= '0;
                else     sync_q <= {sync_q[SYNC_STAGES-2:0], strobe_in};
            end
        end
    endgenerate

    assign strobe_s = sync_q[SYNC_STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) strobe_prev <= 1'b0;
        else     strobe_prev <= strobe_s;
    end

    always_comb begin
        rise_ev = strobe_s && !strobe_prev;
        fall_ev = !strobe_s && strobe_prev;
        tmr_hit = tmr_ovf[mode[1:0]];
        unique case (mode)
            UPD_TMR0, UPD_TMR1, UPD_TMR2, UPD_TMR3: commit = tmr_hit;
            UPD_RISE:  commit = rise_ev;
            UPD_FALL:  commit = fall_ev;
            UPD_BOTH:  commit = rise_ev || fall_ev;
            default:   commit = hi_wr;
        endcase
    end
endmodule

// File: rtl/dacu_latch.sv
module dacu_latch
    import dacu_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              commit,
    input  logic [CODE_W-1:0] word_in,
    output logic [CODE_W-1:0] code_q
);
    always_ff @(posedge clk) begin
        if (rst)         code_q <= '0;
        else if (commit) code_q <= word_in;
    end
endmodule

// File: rtl/dac_update_ctrl.sv
module dac_update_ctrl
    import dacu_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               wr_en,
    input  logic [ADDR_W-1:0]  wr_addr,
    input  logic [BYTE_W-1:0]  wr_data,
    input  logic [ADDR_W-1:0]  rd_addr,
    output logic [BYTE_W-1:0]  rd_data,
    input  logic [NUM_TMR-1:0] tmr_ovf,
    input  logic               strobe_in,
    output logic [CODE_W-1:0]  dac_code,
    output logic [RANGE_W-1:0] fs_range
);
    ctrl_t             ctrl_q;
    logic [BYTE_W-1:0] hold_hi, hold_lo;
    logic              hi_wr, commit;
    logic [CODE_W-1:0] word_in;

    dacu_regs u_regs (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .ctrl_q(ctrl_q),
        .hold_hi(hold_hi), .hold_lo(hold_lo), .hi_wr(hi_wr)
    );

    dacu_trigger #(.SYNC_STAGES(SYNC_STAGES)) u_trig (
        .clk(clk), .rst(rst), .mode(ctrl_q.mode), .tmr_ovf(tmr_ovf),
        .strobe_in(strobe_in), .hi_wr(hi_wr), .commit(commit)
    );

    // In write-commit mode the new high byte is taken straight from the bus.
    always_comb begin
        if (ctrl_q.mode == UPD_WRITE) word_in = join_word(wr_data, hold_lo);
        else                          word_in = join_word(hold_hi, hold_lo);
    end

    dacu_latch u_latch (
        .clk(clk), .rst(rst), .commit(commit), .word_in(word_in), .code_q(dac_code)
    );

    assign fs_range = ctrl_q.range;
endmodule

// File: rtl/dacu_checker.sv
module dacu_checker
    import dacu_pkg::*;
(
    input logic               clk,
    input logic               rst,
    input logic               wr_en,
    input logic [ADDR_W-1:0]  wr_addr,
    input logic [BYTE_W-1:0]  wr_data,
    input logic [ADDR_W-1:0]  rd_addr,
    input logic [BYTE_W-1:0]  rd_data,
    input logic [NUM_TMR-1:0] tmr_ovf,
    input logic [CODE_W-1:0]  dac_code,
    input logic [RANGE_W-1:0] fs_range,
    input logic [MODE_W-1:0]  mode,
    input logic [BYTE_W-1:0]  hold_hi,
    input logic [BYTE_W-1:0]  hold_lo
);
    p_reset_state_r1: assert property (@(posedge clk)
        rst |=> (dac_code == '0 && fs_range == RANGE_RST));

    p_lo_masked_r3: assert property (@(posedge clk) disable iff (rst)
        (rd_addr == REG_LO) |-> (rd_data[5:0] == 6'd0));

    p_timer_hold_r4: assert property (@(posedge clk) disable iff (rst)
        (!mode[2] && !tmr_ovf[mode[1:0]]) |=> $stable(dac_code));

    p_timer_commit_r5: assert property (@(posedge clk) disable iff (rst)
        (!mode[2] && tmr_ovf[mode[1:0]]) |=>
            (dac_code == $past({hold_hi, hold_lo[7:6]})));

    p_write_commit_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b111 && wr_en && wr_addr == REG_HI) |=>
            (dac_code == $past({wr_data, hold_lo[7:6]})));

    p_write_hold_r9: assert property (@(posedge clk) disable iff (rst)
        (mode == 3'b111 && !(wr_en && wr_addr == REG_HI)) |=> $stable(dac_code));

    p_range_follow_r11: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == REG_CTRL) |=> (fs_range == $past(wr_data[1:0])));
endmodule

bind dac_update_ctrl dacu_checker u_chk (
    .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
    .rd_addr(rd_addr), .rd_data(rd_data), .tmr_ovf(tmr_ovf), .dac_code(dac_code),
    .fs_range(fs_range), .mode(ctrl_q.mode), .hold_hi(hold_hi), .hold_lo(hold_lo)
);

// File: tb/dac_update_ctrl_test.sv
`timescale 1ns/1ps
module dac_update_ctrl_test;
    logic       clk = 1'b0;
    logic       rst;
    logic       wr_en;
    logic [1:0] wr_addr;
    logic [7:0] wr_data;
    logic [1:0] rd_addr;
    logic [7:0] rd_data;
    logic [3:0] tmr_ovf;
    logic       strobe_in;
    logic [9:0] dac_code;
    logic [1:0] fs_range;

    int errors = 0;
    int checks = 0;
    logic [7:0] exp_hi, exp_lo;
    logic [9:0] exp_code;

    always #2 clk = ~clk;

    dac_update_ctrl uut (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .rd_addr(rd_addr), .rd_data(rd_data), .tmr_ovf(tmr_ovf),
        .strobe_in(strobe_in), .dac_code(dac_code), .fs_range(fs_range)
    );

    function automatic logic [9:0] word_of(input logic [7:0] hi, input logic [7:0] lo);
        return {hi, lo[7:6]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=0x%0h expected=0x%0h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic set_mode(input logic [2:0] m, input logic [1:0] rg);
        wr(2'd0, {1'b0, m, 2'b00, rg});
    endtask

    task automatic load(input logic [7:0] hi, input logic [7:0] lo);
        wr(2'd1, hi); wr(2'd2, lo);
        exp_hi = hi; exp_lo = lo;
    endtask

    task automatic strobe_to(input logic lvl, input bit expect_commit, input string req);
        strobe_in = lvl;
        @(negedge clk); @(negedge clk);
        check(req, dac_code, exp_code);
        @(negedge clk);
        if (expect_commit) exp_code = word_of(exp_hi, exp_lo);
        check(req, dac_code, exp_code);
    endtask

    initial begin
        #400000;
        errors++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        void'($urandom(32'd4242));
        rst = 1'b1; wr_en = 0; wr_addr = 0; wr_data = 0; rd_addr = 0;
        tmr_ovf = 0; strobe_in = 0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R1 reset state
        check("R1 code", dac_code, 10'h000);
        check("R1 range", fs_range, 2'b10);
        rd_addr = 2'd0; #0.1;
        check("R1 ctrl readback", rd_data, 8'h02);
        exp_code = 10'h000;

        // R2/R3 readback and masking (mode 000, range 10 written back)
        wr(2'd0, 8'hFF);
        rd_addr = 2'd0; #0.1;
        check("R3 ctrl mask", rd_data, 8'h73);
        check("R11 range on write", fs_range, 2'b11);
        set_mode(3'b000, 2'b10);
        load(8'hA5, 8'hFF);
        rd_addr = 2'd1; #0.1;
        check("R2 high readback", rd_data, 8'hA5);
        rd_addr = 2'd2; #0.1;
        check("R3 low mask", rd_data, 8'hC0);
        rd_addr = 2'd3; #0.1;
        check("R2 unused addr", rd_data, 8'h00);
        check("R4 held before event", dac_code, exp_code);

        // R10 corner words via timer 0
        foreach (exp_hi[i]) ; // no-op to keep loop variable rules simple
        for (int k = 0; k < 4; k++) begin
            logic [7:0] h, l;
            h = (k == 0) ? 8'h00 : (k == 1) ? 8'h00 : (k == 2) ? 8'h80 : 8'hFF;
            l = (k == 0) ? 8'h00 : (k == 1) ? 8'h40 : (k == 2) ? 8'h00 : 8'hFF;
            load(h, l);
            tmr_ovf = 4'b0001; @(negedge clk); tmr_ovf = 0;
            exp_code = word_of(h, l);
            check("R10 corner word", dac_code, exp_code);
        end

        // R4/R5/R11 random timer modes
        for (int n = 0; n < 60; n++) begin
            logic [2:0] m; logic [1:0] rg, idx;
            m = 3'($urandom % 4); rg = 2'($urandom); idx = 2'($urandom);
            set_mode(m, rg);
            check("R11 range", fs_range, rg);
            load(8'($urandom), 8'($urandom));
            check("R4 no early update", dac_code, exp_code);
            tmr_ovf = 4'b0001 << idx; @(negedge clk); tmr_ovf = 0;
            if (idx == m[1:0]) exp_code = word_of(exp_hi, exp_lo);
            check("R5 timer select", dac_code, exp_code);
        end

        // R6 rising edge mode
        set_mode(3'b100, 2'b10);
        load(8'h3C, 8'h80);
        strobe_to(1'b1, 1'b1, "R6 rise");
        load(8'h11, 8'h40);
        strobe_to(1'b0, 1'b0, "R6 fall ignored");
        tmr_ovf = 4'b1111; @(negedge clk); tmr_ovf = 0;
        check("R6 timers ignored", dac_code, exp_code);
        strobe_to(1'b1, 1'b1, "R6 rise again");

        // R7 falling edge mode
        set_mode(3'b101, 2'b01);
        load(8'hC3, 8'hC0);
        strobe_to(1'b0, 1'b1, "R7 fall");
        load(8'h5A, 8'h00);
        strobe_to(1'b1, 1'b0, "R7 rise ignored");
        strobe_to(1'b0, 1'b1, "R7 fall again");

        // R8 both edges
        set_mode(3'b110, 2'b00);
        check("R11 0.5mA", fs_range, 2'b00);
        load(8'h77, 8'h40);
        strobe_to(1'b1, 1'b1, "R8 rise");
        load(8'h88, 8'h80);
        strobe_to(1'b0, 1'b1, "R8 fall");

        // R9 write-commit mode
        set_mode(3'b111, 2'b10);
        wr(2'd2, 8'hC0); exp_lo = 8'hC0;
        check("R9 low write alone", dac_code, exp_code);
        wr(2'd1, 8'h12); exp_hi = 8'h12;
        exp_code = word_of(exp_hi, exp_lo);
        check("R9 commit on high write", dac_code, exp_code);
        wr(2'd2, 8'h40); exp_lo = 8'h40;
        tmr_ovf = 4'b1111; @(negedge clk); tmr_ovf = 0;
        strobe_to(1'b1, 1'b0, "R9 strobe ignored");
        check("R9 timers ignored", dac_code, exp_code);
        wr(2'd1, 8'hFE); exp_hi = 8'hFE;
        exp_code = word_of(exp_hi, exp_lo);
        check("R9 commit uses held low", dac_code, exp_code);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule